// File: doc/BRIEF.md
# Interval Timer with Reload

This block is a programmable interval timer for a processor's system register space. It holds a count register that counts upward, one step per tick-enable pulse, while the run bit is set. When the count passes its all-ones value it wraps, records the event in a done flag, and raises an interrupt request if interrupts are enabled. A second wrap before software has acknowledged the first sets an error flag. While running, each wrap reloads the count from a next-interval register. Software therefore programs the next interval as the two's complement of the wanted period.

Software reaches the timer through a simple register port: one write channel and one independent combinational read channel. Writes to the control register can also issue two one-shot commands. The transfer command loads the count from the next-interval register. The single-step command advances the stopped counter by one. The microsecond tick is produced elsewhere and arrives as a one-cycle enable.

Top module: `interval_timer`

## Requirements
- R1: After reset the control word, count and next-interval registers all read zero and `irq` is low.
- R2: The control register sits at address 0 and reads error at bit 31, done at bit 7, interrupt enable at bit 6 and run at bit 0. All other bits, including the write-only transfer (bit 4) and single-step (bit 5) commands, read as zero.
- R3: The count register (address 1) increases by one on each cycle in which `tick_en` is high and run is set. It is unchanged when run is clear.
- R4: When a tick carries the count from all-ones while running, the count loads the next-interval value.
- R5: A wrap sets done if done is clear, and sets error instead if done is already set.
- R6: A control write clears error and done where the written bit (31 or 7) is one. It leaves them unchanged where the bit is zero. It stores interrupt enable and run as written.
- R7: On a wrap, `irq` becomes the interrupt-enable value in force after that cycle: high if enabled, low if not.
- R8: After any control write, `irq` is low unless both done and interrupt enable are set.
- R9: A control write with the transfer bit set copies the next-interval register into the count.
- R10: A control write with single-step set and run written as zero adds one to the count, after any transfer in the same write. If the count was all-ones it loads the next-interval value and is treated as a wrap (R5, R7). With run written as one, single-step has no effect.
- R11: The next-interval register (address 2) is fully read/write. Writes to the count address are ignored.
- R12: A tick arriving in the same cycle as a control write is dropped and does not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | One-cycle count enable (microsecond tick) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 count, 2 next interval |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data for `rd_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The counter is exercised with plain tick bursts, with ticks while stopped, and with ticks held high across a control write. These separate real counting from the run gate and from write priority. Wraps are driven three ways: by ticks with done clear, by ticks with done already set, and by single-step from the stopped state. This separates the done path from error escalation and the tick path from the command path. Control writes are issued with every combination of the acknowledge bits and the enable bit that matters to `irq`, and with transfer and single-step together, so that the ordering within one write is observed.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CNT  = 2'd1,
    ADDR_NEXT = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  localparam int BIT_ERR  = DATA_W - 1;
  localparam int BIT_DONE = 7;
  localparam int BIT_IE   = 6;
  localparam int BIT_SGL  = 5;
  localparam int BIT_XFR  = 4;
  localparam int BIT_RUN  = 0;

  typedef struct packed {
    logic clr_err;
    logic clr_done;
    logic ie;
    logic sgl;
    logic xfr;
    logic run;
  } ctrl_cmd_t;
endpackage

// File: rtl/timer_regbus.sv
module timer_regbus
  import timer_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  input  logic         st_err,
  input  logic         st_done,
  input  logic         st_ie,
  input  logic         st_run,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] nicr,
  output logic         ctrl_wr,
  output ctrl_cmd_t    cmd
);
  localparam logic [W-1:0] RD_MASK =
    (W'(1) << BIT_ERR) | (W'(1) << BIT_DONE) | (W'(1) << BIT_IE) | (W'(1) << BIT_RUN);

  logic         nicr_we;
  logic [W-1:0] ctrl_rd;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
  assign nicr_we = wr_en && (wr_addr == ADDR_NEXT);

  always_comb begin
    cmd.clr_err  = wr_data[BIT_ERR];
    cmd.clr_done = wr_data[BIT_DONE];
    cmd.ie       = wr_data[BIT_IE];
    cmd.sgl      = wr_data[BIT_SGL];
    cmd.xfr      = wr_data[BIT_XFR];
    cmd.run      = wr_data[BIT_RUN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nicr <= '0;
    end else if (nicr_we) begin
      nicr <= wr_data;
    end
  end

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[BIT_ERR]  = st_err;
    ctrl_rd[BIT_DONE] = st_done;
    ctrl_rd[BIT_IE]   = st_ie;
    ctrl_rd[BIT_RUN]  = st_run;
    unique case (rd_addr)
      ADDR_CTRL: rd_data = ctrl_rd;
      ADDR_CNT:  rd_data = cnt;
      ADDR_NEXT: rd_data = nicr;
      default:   rd_data = '0;
    endcase
  end

  AST_CTRL_RD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADDR_CTRL) |-> ((rd_data & ~RD_MASK) == '0)); // R2

  AST_NEXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !nicr_we |=> $stable(nicr)); // R11
endmodule

// File: rtl/timer_counter.sv
module timer_counter
  import timer_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         run,
  input  logic         ctrl_wr,
  input  ctrl_cmd_t    cmd,
  input  logic [W-1:0] nicr,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_n;
  logic [W-1:0] base;
  logic         cnt_en;

  // A control write owns the counter for its cycle; a coincident tick is dropped.
  always_comb begin
    cnt_n  = cnt;
    ovf    = 1'b0;
    base   = cmd.xfr ? nicr : cnt;
    cnt_en = ctrl_wr || (run && tick_en);
    if (ctrl_wr) begin
      cnt_n = base;
      if (!cmd.run && cmd.sgl) begin
        if (base == CNT_MAX) begin
          cnt_n = nicr;
          ovf   = 1'b1;
        end else begin
          cnt_n = base + 1'b1;
        end
      end
    end else if (run && tick_en) begin
      if (cnt == CNT_MAX) begin
        cnt_n = nicr;
        ovf   = 1'b1;
      end else begin
        cnt_n = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_n;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_en && !ctrl_wr && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1)); // R3

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_en && !ctrl_wr && cnt == CNT_MAX) |=> (cnt == $past(nicr))); // R4

  AST_XFR_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && cmd.xfr && !(cmd.sgl && !cmd.run)) |=> (cnt == $past(nicr))); // R9

  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && !run) |=> $stable(cnt)); // R3
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ctrl_wr,
  input  ctrl_cmd_t cmd,
  input  logic      ovf,
  output logic      err,
  output logic      done,
  output logic      ie,
  output logic      run,
  output logic      irq
);
  logic err_n, done_n, ie_n, run_n, irq_n;
  logic err_c, done_c;

  // Acknowledge clears come first, then the wrap event sees the cleared flags.
  always_comb begin
    err_c  = err  & ~(ctrl_wr & cmd.clr_err);
    done_c = done & ~(ctrl_wr & cmd.clr_done);
    ie_n   = ctrl_wr ? cmd.ie  : ie;
    run_n  = ctrl_wr ? cmd.run : run;
    err_n  = err_c;
    done_n = done_c;
    irq_n  = irq;
    if (ovf) begin
      if (done_c) begin
        err_n = 1'b1;
      end else begin
        done_n = 1'b1;
      end
      irq_n = ie_n;
    end
    if (ctrl_wr && !(done_n && ie_n)) begin
      irq_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err  <= 1'b0;
      done <= 1'b0;
      ie   <= 1'b0;
      run  <= 1'b0;
      irq  <= 1'b0;
    end else begin
      err  <= err_n;
      done <= done_n;
      ie   <= ie_n;
      run  <= run_n;
      irq  <= irq_n;
    end
  end

  AST_ERR_ESCALATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && done && !(ctrl_wr && cmd.clr_done)) |=> err); // R5

  AST_DONE_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> done); // R5

  AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (!irq || (done && ie))); // R8

  AST_IRQ_NEEDS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ovf)); // R7
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic         irq
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_int_n;
  logic                   ctrl_wr, ovf;
  logic                   st_err, st_done, st_ie, st_run;
  logic [W-1:0]           cnt, nicr;
  ctrl_cmd_t              cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= '0;
    end else begin
      rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[SYNC_STAGES-1];

  timer_regbus #(.W(W)) u_regbus (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .st_err  (st_err),
    .st_done (st_done),
    .st_ie   (st_ie),
    .st_run  (st_run),
    .cnt     (cnt),
    .rd_data (rd_data),
    .nicr    (nicr),
    .ctrl_wr (ctrl_wr),
    .cmd     (cmd)
  );

  timer_counter #(.W(W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick_en (tick_en),
    .run     (st_run),
    .ctrl_wr (ctrl_wr),
    .cmd     (cmd),
    .nicr    (nicr),
    .cnt     (cnt),
    .ovf     (ovf)
  );

  timer_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ctrl_wr (ctrl_wr),
    .cmd     (cmd),
    .ovf     (ovf),
    .err     (st_err),
    .done    (st_done),
    .ie      (st_ie),
    .run     (st_run),
    .irq     (irq)
  );
endmodule

// File: tb/interval_timer_bench.sv
`timescale 1ns/1ps
module interval_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic        irq;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;

  int          q_kind[$];
  logic [1:0]  q_addr[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  interval_timer u_interval_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  // Monitor: pops expected items and compares against the ports.
  initial begin
    rd_addr = 2'd0;
    forever begin
      @(negedge clk);
      while (q_kind.size() != 0) begin
        automatic int          k = q_kind.pop_front();
        automatic logic [1:0]  a = q_addr.pop_front();
        automatic logic [31:0] e = q_exp.pop_front();
        automatic string       t = q_tag.pop_front();
        automatic logic [31:0] act;
        rd_addr = a;
        #1;
        act = (k == 1) ? {31'd0, irq} : rd_data;
        checks++;
        if (act !== e) begin
          errors++;
          $display("FAIL %s kind=%0d addr=%0d actual=%h expected=%h", t, k, a, act, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic exp_reg(input logic [1:0] a, input logic [31:0] e, input string t);
    q_kind.push_back(0); q_addr.push_back(a); q_exp.push_back(e); q_tag.push_back(t);
  endtask

  task automatic exp_irq(input logic e, input string t);
    q_kind.push_back(1); q_addr.push_back(2'd0); q_exp.push_back({31'd0, e}); q_tag.push_back(t);
  endtask

  task automatic drain();
    while (q_kind.size() != 0) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input bit with_tick = 0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick_en = with_tick;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    exp_reg(2'd0, 32'h0, "R1 ctrl"); exp_reg(2'd1, 32'h0, "R1 count");
    exp_reg(2'd2, 32'h0, "R1 next"); exp_irq(1'b0, "R1 irq"); drain();

    // R11 next-interval read/write, count writes ignored
    wr(2'd2, 32'h1234_5678); wr(2'd1, 32'h0000_DEAD);
    exp_reg(2'd2, 32'h1234_5678, "R11 next rw"); exp_reg(2'd1, 32'h0, "R11 count write ignored"); drain();

    // R2 / R9 all bits written: transfer, run, ie; single-step ignored under run
    wr(2'd0, 32'hFFFF_FFFF);
    exp_reg(2'd0, 32'h0000_0041, "R2 read mask"); exp_reg(2'd1, 32'h1234_5678, "R9 transfer");
    exp_irq(1'b0, "R8 irq after write"); drain();

    // R3 counting and stopped hold
    ticks(5); exp_reg(2'd1, 32'h1234_567D, "R3 count 5 ticks"); drain();
    wr(2'd0, 32'h0000_0040); ticks(3);
    exp_reg(2'd1, 32'h1234_567D, "R3 stopped hold"); drain();

    // R4 R5 R7 first wrap
    wr(2'd2, 32'hFFFF_FFFE); wr(2'd0, 32'h0000_0051); wr(2'd2, 32'h0000_0100);
    ticks(1); exp_reg(2'd1, 32'hFFFF_FFFF, "R3 near wrap"); exp_irq(1'b0, "R7 before wrap"); drain();
    ticks(1);
    exp_reg(2'd1, 32'h0000_0100, "R4 reload"); exp_reg(2'd0, 32'h0000_00C1, "R5 done set");
    exp_irq(1'b1, "R7 irq on wrap"); drain();

    // R5 error escalation, R8 irq held when done and ie
    wr(2'd2, 32'hFFFF_FFFF); wr(2'd0, 32'h0000_0051);
    exp_irq(1'b1, "R8 irq kept"); exp_reg(2'd1, 32'hFFFF_FFFF, "R9 transfer max"); drain();
    ticks(1);
    exp_reg(2'd0, 32'h8000_00C1, "R5 error set"); exp_reg(2'd1, 32'hFFFF_FFFF, "R4 reload max"); drain();

    // R6 clear error only
    wr(2'd0, 32'h8000_0041);
    exp_reg(2'd0, 32'h0000_00C1, "R6 clear err"); exp_irq(1'b1, "R8 irq kept 2"); drain();

    // R8 ie off clears irq; R6 zero bit leaves done
    wr(2'd0, 32'h0000_0001);
    exp_irq(1'b0, "R8 irq cleared"); exp_reg(2'd0, 32'h0000_0081, "R6 done kept"); drain();

    // R7 wrap without ie keeps irq low
    wr(2'd0, 32'h0000_0081); exp_reg(2'd0, 32'h0000_0001, "R6 clear done"); drain();
    ticks(1);
    exp_irq(1'b0, "R7 no irq without ie"); exp_reg(2'd0, 32'h0000_0081, "R5 done again"); drain();

    // R12 tick coincident with control write dropped
    wr(2'd0, 32'h0000_0081, 1);
    exp_reg(2'd1, 32'hFFFF_FFFF, "R12 tick dropped"); exp_reg(2'd0, 32'h0000_0001, "R12 ctrl"); drain();

    // R10 single-step wrap and plain step
    wr(2'd0, 32'h0000_0000); wr(2'd2, 32'h0000_0055); wr(2'd0, 32'h0000_0020);
    exp_reg(2'd1, 32'h0000_0055, "R10 step wrap reload"); exp_reg(2'd0, 32'h0000_0080, "R10 step sets done"); drain();
    wr(2'd0, 32'h0000_0020);
    exp_reg(2'd1, 32'h0000_0056, "R10 step"); drain();

    // R10 single-step ignored with run
    wr(2'd0, 32'h0000_0021);
    exp_reg(2'd1, 32'h0000_0056, "R10 step ignored under run"); exp_reg(2'd0, 32'h0000_0081, "R10 ctrl"); drain();
    wr(2'd0, 32'h0000_0080); exp_reg(2'd0, 32'h0, "R6 all clear"); drain();

    // R9 R10 transfer then step in one write
    wr(2'd2, 32'h0000_0010); wr(2'd0, 32'h0000_0030);
    exp_reg(2'd1, 32'h0000_0011, "R10 transfer then step"); drain();

    // R7 single-step wrap with ie raises irq
    wr(2'd2, 32'hFFFF_FFFF); wr(2'd0, 32'h0000_0050); wr(2'd0, 32'h0000_0060);
    exp_irq(1'b1, "R7 irq on step wrap"); exp_reg(2'd0, 32'h0000_00C0, "R10 step wrap flags"); drain();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule